// File: doc/BRIEF.md
# Period-Match Peripheral Timer

This block is a 16-bit up-counting timer that sits on a simple register port. Software programs a period value and a starting count, picks a clock source and a prescale ratio, and then enables the timer. The counter then advances on each prescaled tick. When the counter arrives at the period value, the timer raises a single-cycle event. On the tick after that, the counter returns to zero.

The tick source is either the internal clock or rising edges of an external pin. The external pin is brought into the clock domain through a two-flop synchronizer. In gated mode the internal clock is counted only while the synchronized pin is high, and the event marks the falling edge of the gate. A stop-in-idle control freezes counting while the idle input is asserted. Each event also sets a sticky flag, which software clears by writing a one.

Top module: `pm_timer16`

## Requirements
- R1: The register port decodes four addresses: 0 is control, 1 is count, 2 is period and 3 is status, where bit 0 holds the sticky flag. The control fields are: enable at bit 15, idle-stop at bit 13, gate mode at bit 7, prescale code at bits 5:4, sync select at bit 2 and source select at bit 1. Control reads return only these bits, with all other bits zero. After reset, control, count and status read 0 and period reads 0xFFFF.
- R2: While the enable bit is 0, the count holds its value and the other control fields keep their written values.
- R3: With source select 0 and prescale code 00, the count advances by one on every clock. The sync select bit then has no effect on the rate.
- R4: Prescale codes 01, 10 and 11 make the count advance once every 8, 64 and 256 counted source events. Code 00 advances it on every event.
- R5: The count reaching the period value raises match_o for exactly one cycle. The next count tick loads zero instead of incrementing.
- R6: With period 0, the count stays at zero and match_o pulses once on every count tick.
- R7: A match event sets the status flag. Writing status with bit 0 = 1 clears it, and writing bit 0 = 0 leaves it set.
- R8: With idle-stop 1, counting halts while idle_i is high and resumes when it falls. With idle-stop 0, idle_i has no effect.
- R9: With source select 1, each rising edge of tmr_pin_i that has passed the synchronizer is one counted source event. A pin held high adds nothing further.
- R10: With gate mode 1 and source select 0, the internal clock is counted only while the synchronized pin is high. A falling edge of the gate raises match_o once, and period equality raises no event in this mode.
- R11: A write to the count register clears the prescaler, so the first tick after the write comes a full prescale interval later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| idle_i | input | 1 | CPU idle indication |
| tmr_pin_i | input | 1 | External clock or gate pin, asynchronous |
| addr_i | input | 2 | Register select |
| wr_i | input | 1 | Register write strobe |
| wdata_i | input | 16 | Register write data |
| rdata_o | output | 16 | Register read data for addr_i, combinational |
| match_o | output | 1 | Single-cycle match or gate-end event |

## Verification
Exact cycle counts through the pin path are the hardest to reach, because every pin change passes through a synchronizer and an edge register before it can tick the counter. The bench holds the pin high for a known number of clocks in gated mode and expects exactly that many counts once the pipeline drains, followed by exactly one falling-edge event. The prescaler-clear-on-write case is also hard to reach. To reach it, the bench writes the count part way through an 8-cycle prescale interval and checks that the next increment comes exactly 8 cycles after the write.

// File: rtl/pmt_pkg.sv
package pmt_pkg;

  localparam int unsigned CTRL_ON_BIT    = 15;
  localparam int unsigned CTRL_ISTOP_BIT = 13;
  localparam int unsigned CTRL_GATE_BIT  = 7;
  localparam int unsigned CTRL_PS_LSB    = 4;
  localparam int unsigned CTRL_SYNC_BIT  = 2;
  localparam int unsigned CTRL_SRC_BIT   = 1;
  localparam int unsigned PS_CNT_W       = 8;

  typedef enum logic [1:0] {
    SEL_CTRL   = 2'd0,
    SEL_COUNT  = 2'd1,
    SEL_PERIOD = 2'd2,
    SEL_STATUS = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic       en;
    logic       idle_stop;
    logic       gate;
    logic [1:0] ps;
    logic       sync;
    logic       src;
  } ctrl_t;

endpackage

// File: rtl/pmt_regs.sv
module pmt_regs
  import pmt_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        addr_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] cnt_i,
  input  logic              evt_i,
  output ctrl_t             ctrl_o,
  output logic [DATA_W-1:0] per_o,
  output logic              cnt_wr_o,
  output logic [DATA_W-1:0] rdata_o
);

  ctrl_t             ctrl_q, ctrl_nxt;
  logic [DATA_W-1:0] per_q, per_nxt;
  logic              flag_q, flag_nxt;
  logic              ctrl_we, per_we, stat_we;

  assign ctrl_we  = wr_i && (reg_sel_e'(addr_i) == SEL_CTRL);
  assign cnt_wr_o = wr_i && (reg_sel_e'(addr_i) == SEL_COUNT);
  assign per_we   = wr_i && (reg_sel_e'(addr_i) == SEL_PERIOD);
  assign stat_we  = wr_i && (reg_sel_e'(addr_i) == SEL_STATUS);

  always_comb begin
    ctrl_nxt = ctrl_q;
    if (ctrl_we) begin
      ctrl_nxt.en        = wdata_i[CTRL_ON_BIT];
      ctrl_nxt.idle_stop = wdata_i[CTRL_ISTOP_BIT];
      ctrl_nxt.gate      = wdata_i[CTRL_GATE_BIT];
      ctrl_nxt.ps        = wdata_i[CTRL_PS_LSB +: 2];
      ctrl_nxt.sync      = wdata_i[CTRL_SYNC_BIT];
      ctrl_nxt.src       = wdata_i[CTRL_SRC_BIT];
    end
  end

  always_comb begin
    per_nxt = per_q;
    if (per_we) begin
      per_nxt = wdata_i;
    end
  end

  // a new event wins over a clear in the same cycle
  always_comb begin
    flag_nxt = flag_q;
    if (stat_we && wdata_i[0]) begin
      flag_nxt = 1'b0;
    end
    if (evt_i) begin
      flag_nxt = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      per_q  <= '1;
      flag_q <= 1'b0;
    end else begin
      ctrl_q <= ctrl_nxt;
      per_q  <= per_nxt;
      flag_q <= flag_nxt;
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (reg_sel_e'(addr_i))
      SEL_CTRL: begin
        rdata_o[CTRL_ON_BIT]       = ctrl_q.en;
        rdata_o[CTRL_ISTOP_BIT]    = ctrl_q.idle_stop;
        rdata_o[CTRL_GATE_BIT]     = ctrl_q.gate;
        rdata_o[CTRL_PS_LSB +: 2]  = ctrl_q.ps;
        rdata_o[CTRL_SYNC_BIT]     = ctrl_q.sync;
        rdata_o[CTRL_SRC_BIT]      = ctrl_q.src;
      end
      SEL_COUNT:  rdata_o = cnt_i;
      SEL_PERIOD: rdata_o = per_q;
      SEL_STATUS: rdata_o[0] = flag_q;
      default:    rdata_o = '0;
    endcase
  end

  assign ctrl_o = ctrl_q;
  assign per_o  = per_q;

  a_r7_flag_sets: assert property (@(posedge clk) disable iff (!rst_n)
    evt_i |=> flag_q);

  a_r7_clear_only_by_w1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(flag_q) && !flag_q |-> $past(stat_we) && $past(wdata_i[0]));

endmodule

// File: rtl/pmt_tick.sv
module pmt_tick
  import pmt_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned PS_W        = PS_CNT_W
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin_i,
  input  logic       on_i,
  input  logic       run_i,
  input  logic       src_i,
  input  logic       gate_i,
  input  logic [1:0] ps_i,
  input  logic       clr_i,
  output logic       tick_o,
  output logic       gate_fall_o,
  output logic       gated_o
);

  logic [SYNC_STAGES-1:0] sync_q, sync_nxt;
  logic                   prev_q;
  logic                   pin_s, rise, fall;
  logic                   src_evt, adv, wrap;
  logic [PS_W-1:0]        pcnt_q, pcnt_nxt, lim;

  generate
    if (SYNC_STAGES >= 2) begin : g_sync_chain
      assign sync_nxt = {sync_q[SYNC_STAGES-2:0], pin_i};
    end else begin : g_sync_single
      assign sync_nxt = pin_i;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_nxt;
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign pin_s   = sync_q[SYNC_STAGES-1];
  assign rise    = pin_s && !prev_q;
  assign fall    = !pin_s && prev_q;
  assign gated_o = gate_i && !src_i;

  always_comb begin
    unique case (ps_i)
      2'b00:   lim = PS_W'(0);
      2'b01:   lim = PS_W'(7);
      2'b10:   lim = PS_W'(63);
      default: lim = PS_W'(255);
    endcase
  end

  always_comb begin
    if (src_i) begin
      src_evt = rise;
    end else if (gated_o) begin
      src_evt = pin_s;
    end else begin
      src_evt = 1'b1;
    end
  end

  assign adv  = run_i && src_evt;
  assign wrap = (pcnt_q >= lim);

  always_comb begin
    pcnt_nxt = pcnt_q;
    if (!on_i || clr_i) begin
      pcnt_nxt = '0;
    end else if (adv) begin
      pcnt_nxt = wrap ? '0 : pcnt_q + PS_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt_q <= '0;
    end else begin
      pcnt_q <= pcnt_nxt;
    end
  end

  assign tick_o      = on_i && !clr_i && adv && wrap;
  assign gate_fall_o = run_i && gated_o && fall;

  a_r4_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o && (lim != '0) && $stable(ps_i) |=> !tick_o);

  a_r9_edge_needs_low: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);

endmodule

// File: rtl/pmt_count.sv
module pmt_count #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic [CNT_W-1:0] per_i,
  input  logic             gated_i,
  input  logic             gate_fall_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             evt_o
);

  logic [CNT_W-1:0] cnt_q, cnt_nxt, step;
  logic             evt_q, evt_nxt;

  assign step = (cnt_q == per_i) ? '0 : cnt_q + CNT_W'(1);

  always_comb begin
    cnt_nxt = cnt_q;
    if (wr_i) begin
      cnt_nxt = wdata_i;
    end else if (tick_i) begin
      cnt_nxt = step;
    end
  end

  always_comb begin
    if (gated_i) begin
      evt_nxt = gate_fall_i;
    end else begin
      evt_nxt = tick_i && !wr_i && (step == per_i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      evt_q <= 1'b0;
    end else begin
      cnt_q <= cnt_nxt;
      evt_q <= evt_nxt;
    end
  end

  assign cnt_o = cnt_q;
  assign evt_o = evt_q;

  a_r5_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
    tick_i && !wr_i && (cnt_q == per_i) |=> (cnt_q == '0));

  a_r6_zero_period: assert property (@(posedge clk) disable iff (!rst_n)
    tick_i && !wr_i && !gated_i && (per_i == '0) |=> evt_q && (cnt_q == '0));

  a_r5_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i && !wr_i |=> $stable(cnt_q));

endmodule

// File: rtl/pm_timer16.sv
module pm_timer16
  import pmt_pkg::*;
#(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             idle_i,
  input  logic             tmr_pin_i,
  input  logic [1:0]       addr_i,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] rdata_o,
  output logic             match_o
);

  logic [1:0]       rst_pipe_q;
  logic             rst_int_n;
  ctrl_t            ctrl;
  logic [CNT_W-1:0] per, cnt;
  logic             cnt_wr, run, tick, gate_fall, gated, evt;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= '0;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_pipe_q[1];

  assign run = ctrl.en && !(ctrl.idle_stop && idle_i);

  pmt_regs #(.DATA_W(CNT_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .addr_i   (addr_i),
    .wr_i     (wr_i),
    .wdata_i  (wdata_i),
    .cnt_i    (cnt),
    .evt_i    (evt),
    .ctrl_o   (ctrl),
    .per_o    (per),
    .cnt_wr_o (cnt_wr),
    .rdata_o  (rdata_o)
  );

  pmt_tick #(.SYNC_STAGES(SYNC_STAGES), .PS_W(PS_CNT_W)) u_tick (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .pin_i       (tmr_pin_i),
    .on_i        (ctrl.en),
    .run_i       (run),
    .src_i       (ctrl.src),
    .gate_i      (ctrl.gate),
    .ps_i        (ctrl.ps),
    .clr_i       (cnt_wr),
    .tick_o      (tick),
    .gate_fall_o (gate_fall),
    .gated_o     (gated)
  );

  pmt_count #(.CNT_W(CNT_W)) u_count (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .tick_i      (tick),
    .wr_i        (cnt_wr),
    .wdata_i     (wdata_i),
    .per_i       (per),
    .gated_i     (gated),
    .gate_fall_i (gate_fall),
    .cnt_o       (cnt),
    .evt_o       (evt)
  );

  assign match_o = evt;

  a_r2_off_holds: assert property (@(posedge clk) disable iff (!rst_int_n)
    !ctrl.en && !cnt_wr |=> $stable(cnt));

  a_r8_idle_freeze: assert property (@(posedge clk) disable iff (!rst_int_n)
    ctrl.en && ctrl.idle_stop && idle_i && !cnt_wr |=> $stable(cnt));

  a_r10_gate_event_only_on_fall: assert property (@(posedge clk) disable iff (!rst_int_n)
    gated && !gate_fall |=> !match_o);

endmodule

// File: tb/pm_timer16_tb.sv
`timescale 1ns/1ps
module pm_timer16_tb;

  localparam logic [1:0] A_CTRL = 2'd0, A_CNT = 2'd1, A_PER = 2'd2, A_STAT = 2'd3;
  localparam logic [15:0] C_ON = 16'h8000, C_ISTOP = 16'h2000, C_GATE = 16'h0080,
                          C_SYNC = 16'h0004, C_SRC = 16'h0002;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        idle;
  logic        pin;
  logic [1:0]  addr;
  logic        wr;
  logic [15:0] wdata;
  logic [15:0] rdata;
  logic        match;
  int          n_cmp = 0;
  int          n_bad = 0;
  bit          done  = 1'b0;

  always #2 clk = ~clk;

  pm_timer16 u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .idle_i    (idle),
    .tmr_pin_i (pin),
    .addr_i    (addr),
    .wr_i      (wr),
    .wdata_i   (wdata),
    .rdata_o   (rdata),
    .match_o   (match)
  );

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [15:0] v);
    addr = a;
    #1 v = rdata;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setup(input logic [15:0] cfg, input logic [15:0] per);
    wr_reg(A_CTRL, cfg);
    wr_reg(A_CNT, 16'h0000);
    wr_reg(A_PER, per);
    wr_reg(A_CTRL, cfg | C_ON);
  endtask

  task automatic t_reset();
    logic [15:0] v;
    rd_reg(A_CTRL, v); check("R1 reset ctrl", v, 0);
    rd_reg(A_CNT, v);  check("R1 reset count", v, 0);
    rd_reg(A_PER, v);  check("R1 reset period", v, 16'hFFFF);
    rd_reg(A_STAT, v); check("R1 reset status", v, 0);
    check("R1 reset match", match, 0);
  endtask

  task automatic t_regs();
    logic [15:0] v;
    wr_reg(A_CTRL, 16'h7FFF);
    rd_reg(A_CTRL, v); check("R1 ctrl mask", v, 16'h20B6);
    wr_reg(A_PER, 16'h1234);
    rd_reg(A_PER, v);  check("R1 period rw", v, 16'h1234);
    wr_reg(A_CNT, 16'h0042);
    rd_reg(A_CNT, v);  check("R1 count rw", v, 16'h0042);
    wr_reg(A_CTRL, 16'h0000);
  endtask

  task automatic t_internal();
    logic [15:0] v;
    setup(16'h0000, 16'hFFFF);
    wait_n(10);
    rd_reg(A_CNT, v); check("R3 1:1 count", v, 10);
    setup(C_SYNC, 16'hFFFF);
    wait_n(7);
    rd_reg(A_CNT, v); check("R3 sync bit ignored", v, 7);
  endtask

  task automatic t_off();
    logic [15:0] v0, v;
    setup(C_ISTOP | 16'h0030, 16'hFFFF);
    wait_n(4);
    wr_reg(A_CTRL, C_ISTOP | 16'h0030);
    rd_reg(A_CNT, v0);
    wait_n(6);
    rd_reg(A_CNT, v);  check("R2 count held while off", v, v0);
    rd_reg(A_CTRL, v); check("R2 fields kept", v, 16'h2030);
  endtask

  task automatic t_presc();
    logic [15:0] v;
    setup(16'h0010, 16'hFFFF);
    wait_n(7);  rd_reg(A_CNT, v); check("R4 1:8 before", v, 0);
    wait_n(1);  rd_reg(A_CNT, v); check("R4 1:8 first", v, 1);
    wait_n(8);  rd_reg(A_CNT, v); check("R4 1:8 second", v, 2);
    setup(16'h0020, 16'hFFFF);
    wait_n(127); rd_reg(A_CNT, v); check("R4 1:64 before", v, 1);
    wait_n(1);   rd_reg(A_CNT, v); check("R4 1:64", v, 2);
    setup(16'h0030, 16'hFFFF);
    wait_n(255); rd_reg(A_CNT, v); check("R4 1:256 before", v, 0);
    wait_n(1);   rd_reg(A_CNT, v); check("R4 1:256", v, 1);
  endtask

  task automatic t_match();
    logic [15:0] v;
    int pulses = 0;
    setup(16'h0000, 16'd5);
    for (int k = 1; k <= 20; k++) begin
      @(negedge clk);
      if (match) pulses++;
      if (k == 5) begin
        rd_reg(A_CNT, v); check("R5 reaches period", v, 5);
        check("R5 match at period", match, 1);
      end
      if (k == 6) begin
        rd_reg(A_CNT, v); check("R5 wrap to zero", v, 0);
        check("R5 single-cycle", match, 0);
      end
    end
    check("R5 pulse count", pulses, 3);
  endtask

  task automatic t_zero();
    logic [15:0] v;
    int pulses = 0;
    int nonzero = 0;
    setup(16'h0010, 16'h0000);
    for (int k = 1; k <= 32; k++) begin
      @(negedge clk);
      if (match) pulses++;
      rd_reg(A_CNT, v);
      if (v != 0) nonzero++;
    end
    check("R6 pulses each tick", pulses, 4);
    check("R6 count stays zero", nonzero, 0);
  endtask

  task automatic t_flag();
    logic [15:0] v;
    wr_reg(A_CTRL, 16'h0000);
    rd_reg(A_STAT, v); check("R7 flag set", v, 1);
    wr_reg(A_STAT, 16'h0000);
    rd_reg(A_STAT, v); check("R7 write 0 keeps", v, 1);
    wr_reg(A_STAT, 16'h0001);
    rd_reg(A_STAT, v); check("R7 write 1 clears", v, 0);
  endtask

  task automatic t_idle();
    logic [15:0] v;
    idle = 1'b1;
    setup(C_ISTOP, 16'hFFFF);
    wait_n(10); rd_reg(A_CNT, v); check("R8 frozen in idle", v, 0);
    idle = 1'b0;
    wait_n(4);  rd_reg(A_CNT, v); check("R8 resumes", v, 4);
    idle = 1'b1;
    setup(16'h0000, 16'hFFFF);
    wait_n(6);  rd_reg(A_CNT, v); check("R8 idle ignored", v, 6);
    idle = 1'b0;
  endtask

  task automatic t_ext();
    logic [15:0] v;
    pin = 1'b0;
    setup(C_SRC, 16'hFFFF);
    for (int i = 0; i < 5; i++) begin
      pin = 1'b1; wait_n(2);
      pin = 1'b0; wait_n(2);
    end
    wait_n(4);
    rd_reg(A_CNT, v); check("R9 edges counted", v, 5);
    pin = 1'b1;
    wait_n(10);
    rd_reg(A_CNT, v); check("R9 level adds one", v, 6);
    pin = 1'b0;
  endtask

  task automatic t_gate();
    logic [15:0] v;
    int pulses = 0;
    pin = 1'b0;
    setup(C_GATE, 16'hFFFF);
    wait_n(6);
    rd_reg(A_CNT, v); check("R10 gate low no count", v, 0);
    pin = 1'b1;
    wait_n(9);
    pin = 1'b0;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      if (match) pulses++;
    end
    rd_reg(A_CNT, v); check("R10 counts gate width", v, 9);
    check("R10 one fall event", pulses, 1);
  endtask

  task automatic t_cwr();
    logic [15:0] v;
    setup(16'h0010, 16'hFFFF);
    wait_n(5);
    wr_reg(A_CNT, 16'd100);
    wait_n(7); rd_reg(A_CNT, v); check("R11 no early tick", v, 100);
    wait_n(1); rd_reg(A_CNT, v); check("R11 full interval", v, 101);
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; idle = 1'b0; pin = 1'b0; addr = 2'd0; wr = 1'b0; wdata = 16'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_regs();
    t_internal();
    t_off();
    t_presc();
    t_match();
    t_zero();
    t_flag();
    t_idle();
    t_ext();
    t_gate();
    t_cwr();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule